// File: doc/BRIEF.md
# Output Port Allocator for a Shared-Queue Router

This block decides, for every output port of a router, which queue may send flits through the output crossbar. Requesters are of two kinds: the per-port input queues and a pool of shared queues that hold packets which lost an earlier allocation. Every requester presents the flit at its head together with the output port that flit targets and flags telling whether it is the first (head) or last (tail) flit of its packet. Each output runs its own round-robin arbiter across all requesters of both kinds.

An output is claimed by a head flit and then belongs to that requester for the whole packet; only the owner's flits cross, and the output is freed when the tail flit leaves. Each output keeps a count of free slots in the downstream input queue: a sent flit uses one, a returned credit restores one. With no credits the output sends nothing and accepts no new owner. The allocation decision is registered, so a head request made in one cycle is granted in the next, and the flit crosses the crossbar during the cycle its grant is visible.

Each output is a three-state machine. PORT_IDLE: no owner; arbitration runs when credits are available, and a winner moves the port to PORT_BUSY (claim). PORT_BUSY: owned, with credit; a departing tail returns it to PORT_IDLE (release), and using the last credit without a return moves it to PORT_WAIT (stall). PORT_WAIT: owned, no credit; the first returned credit moves it back to PORT_BUSY (resume).

Top module: `egress_allocator`

## Requirements
- R1: After reset every output is in PORT_IDLE with no grant, no flit crossing, no source popped, and a credit count equal to BUF_DEPTH.
- R2: A head request made while an output is idle and has credit is granted in the next cycle: out_grant for that output becomes one-hot at the source index (0..NUM_OUT-1 input queues, NUM_OUT.. shared queues), xbar_sel carries that index, and the owner's flit crosses (out_valid and its src_pop bit high) in that same cycle; no flit crosses in the request cycle.
- R3: A request with req_head low never claims an idle output.
- R4: When several head requests meet at an idle output, the winner is the first requesting index after the previous winner of that output, wrapping from the top index to 0; the first winner after reset is the lowest requesting index.
- R5: While an output is owned, requests of all other sources to it are masked: the owner stays, and no other source's src_pop bit rises for that output.
- R6: When the owner's flit with req_tail high crosses, the output is idle (no grant) in the following cycle and a new head request may be arbitrated then.
- R7: Each crossing flit takes one credit and each credit_ret pulse adds one; an owned output with zero credits sends nothing but keeps its owner, and an idle output with zero credits grants no one. A send and a credit return in the same cycle leave the count unchanged.
- R8: A source owns at most one output at a time; a source that owns an output cannot win another.
- R9: Different outputs are allocated independently and may grant and send in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | SRC | A flit is presented at the head of each source |
| req_port | input | SRC x PW | Target output port of each source's head flit |
| req_head | input | SRC | Presented flit is the first of its packet |
| req_tail | input | SRC | Presented flit is the last of its packet |
| credit_ret | input | NUM_OUT | One credit returned by the downstream queue of each output |
| out_grant | output | NUM_OUT x SRC | One-hot owner of each output, zero when idle |
| xbar_sel | output | NUM_OUT x SW | Crossbar select: source index driving each output |
| out_valid | output | NUM_OUT | A flit crosses to each output this cycle |
| src_pop | output | SRC | The flit of each source is taken this cycle |

## Verification
The two functions that can land in one cycle are a flit send that uses the last credit and a credit return. The bench drains an output to zero credits inside a long packet, returns one credit to resume it, and then returns another credit in exactly the cycle the next body flit crosses. It judges the overlap by requiring the tail to cross in the very next cycle with no stall, which holds only if the decrement and increment cancel.

// File: rtl/egress_alloc_pkg.sv
package egress_alloc_pkg;

    typedef enum logic [1:0] {
        PORT_IDLE = 2'd0,
        PORT_WAIT = 2'd1,
        PORT_BUSY = 2'd2
    } port_state_e;

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] win_idx
);

    int cand;

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        cand    = 0;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(last) + k) % N;
            if (!found && req[cand]) begin
                found   = 1'b1;
                win_idx = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/credit_tracker.sv
module credit_tracker #(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic has_credit,
    output logic zero_next
);

    logic [CW-1:0] count_q;
    logic [CW-1:0] count_d;

    always_comb begin
        count_d = count_q;
        if (take && !give) begin
            count_d = count_q - CW'(1);
        end else if (give && !take) begin
            count_d = count_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= CW'(DEPTH);
        end else begin
            count_q <= count_d;
        end
    end

    assign has_credit = (count_q != '0);
    assign zero_next  = (count_d == '0);

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (count_q != '0));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

endmodule

// File: rtl/egress_port_ctrl.sv
module egress_port_ctrl
    import egress_alloc_pkg::*;
#(
    parameter int SRC   = 8,
    parameter int DEPTH = 4,
    parameter int SW    = $clog2(SRC)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SRC-1:0] hit,
    input  logic [SRC-1:0] head,
    input  logic [SRC-1:0] tail,
    input  logic [SRC-1:0] locked,
    input  logic           credit_ret,
    output logic [SRC-1:0] grant_vec,
    output logic [SW-1:0]  owner,
    output logic           fire
);

    port_state_e    state_q, state_d;
    logic [SW-1:0]  owner_q, owner_d;
    logic [SW-1:0]  ptr_q, ptr_d;
    logic [SRC-1:0] cand;
    logic           arb_found;
    logic [SW-1:0]  arb_idx;
    logic           has_credit;
    logic           zero_next;
    logic           last_flit;

    assign cand = hit & head & ~locked;

    rr_pick #(.N(SRC), .IW(SW)) u_pick (
        .req     (cand),
        .last    (ptr_q),
        .found   (arb_found),
        .win_idx (arb_idx)
    );

    credit_tracker #(.DEPTH(DEPTH)) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (fire),
        .give       (credit_ret),
        .has_credit (has_credit),
        .zero_next  (zero_next)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
            owner_q <= '0;
            ptr_q   <= SW'(SRC - 1);
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            ptr_q   <= ptr_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        owner_d   = owner_q;
        ptr_d     = ptr_q;
        fire      = 1'b0;
        last_flit = 1'b0;
        grant_vec = '0;
        unique case (state_q)
            PORT_IDLE: begin
                if (has_credit && arb_found) begin
                    state_d = PORT_BUSY;
                    owner_d = arb_idx;
                    ptr_d   = arb_idx;
                end
            end
            PORT_BUSY: begin
                grant_vec[owner_q] = 1'b1;
                fire      = hit[owner_q];
                last_flit = fire && tail[owner_q];
                if (last_flit) begin
                    state_d = PORT_IDLE;
                end else if (zero_next) begin
                    state_d = PORT_WAIT;
                end
            end
            PORT_WAIT: begin
                grant_vec[owner_q] = 1'b1;
                if (!zero_next) begin
                    state_d = PORT_BUSY;
                end
            end
            default: begin
                state_d = PORT_IDLE;
            end
        endcase
    end

    assign owner = owner_q;

    // R2
    grant_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PORT_IDLE && has_credit && (|cand)) |=> (state_q == PORT_BUSY));

    // R5
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PORT_IDLE && !last_flit) |=> $stable(owner_q));

    // R6
    tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_flit |=> (state_q == PORT_IDLE));

    // R7
    zero_credit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PORT_IDLE && !has_credit) |=> (state_q == PORT_IDLE));

    // R7
    busy_has_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PORT_BUSY) |-> has_credit);

endmodule

// File: rtl/egress_allocator.sv
module egress_allocator #(
    parameter int NUM_OUT    = 5,
    parameter int NUM_SHARED = 3,
    parameter int BUF_DEPTH  = 4,
    localparam int SRC = NUM_OUT + NUM_SHARED,
    localparam int SW  = $clog2(SRC),
    localparam int PW  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SRC-1:0]               req_valid,
    input  logic [SRC-1:0][PW-1:0]       req_port,
    input  logic [SRC-1:0]               req_head,
    input  logic [SRC-1:0]               req_tail,
    input  logic [NUM_OUT-1:0]           credit_ret,
    output logic [NUM_OUT-1:0][SRC-1:0]  out_grant,
    output logic [NUM_OUT-1:0][SW-1:0]   xbar_sel,
    output logic [NUM_OUT-1:0]           out_valid,
    output logic [SRC-1:0]               src_pop
);

    logic [NUM_OUT-1:0][SRC-1:0] hit;
    logic [NUM_OUT-1:0][SRC-1:0] locked;
    logic [SRC-1:0][NUM_OUT-1:0] own_col;

    always_comb begin
        for (int o = 0; o < NUM_OUT; o++) begin
            for (int s = 0; s < SRC; s++) begin
                hit[o][s] = req_valid[s] && (req_port[s] == PW'(o));
            end
        end
    end

    always_comb begin
        for (int o = 0; o < NUM_OUT; o++) begin
            locked[o] = '0;
            for (int q = 0; q < NUM_OUT; q++) begin
                if (q != o) begin
                    locked[o] = locked[o] | out_grant[q];
                end
            end
        end
    end

    generate
        for (genvar o = 0; o < NUM_OUT; o++) begin : g_port
            egress_port_ctrl #(
                .SRC   (SRC),
                .DEPTH (BUF_DEPTH),
                .SW    (SW)
            ) u_ctrl (
                .clk        (clk),
                .rst_n      (rst_n),
                .hit        (hit[o]),
                .head       (req_head),
                .tail       (req_tail),
                .locked     (locked[o]),
                .credit_ret (credit_ret[o]),
                .grant_vec  (out_grant[o]),
                .owner      (xbar_sel[o]),
                .fire       (out_valid[o])
            );
        end
    endgenerate

    always_comb begin
        src_pop = '0;
        for (int o = 0; o < NUM_OUT; o++) begin
            for (int s = 0; s < SRC; s++) begin
                if (out_valid[o] && xbar_sel[o] == SW'(s)) begin
                    src_pop[s] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int s = 0; s < SRC; s++) begin
            for (int o = 0; o < NUM_OUT; o++) begin
                own_col[s][o] = out_grant[o][s];
            end
        end
    end

    generate
        for (genvar s = 0; s < SRC; s++) begin : g_src_chk
            // R8
            single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(own_col[s]));

            // R5
            pop_by_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                src_pop[s] |-> (|own_col[s]));
        end
    endgenerate

endmodule

// File: tb/test_egress_allocator.sv
module test_egress_allocator;

    localparam int NO  = 5;
    localparam int NS  = 3;
    localparam int SRC = NO + NS;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [SRC-1:0]          rv = '0;
    logic [SRC-1:0][2:0]     rp = '0;
    logic [SRC-1:0]          rh = '0;
    logic [SRC-1:0]          rt = '0;
    logic [NO-1:0]           cr = '0;
    logic [NO-1:0][SRC-1:0]  og;
    logic [NO-1:0][2:0]      xs;
    logic [NO-1:0]           ov;
    logic [SRC-1:0]          sp;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    egress_allocator #(.NUM_OUT(NO), .NUM_SHARED(NS), .BUF_DEPTH(4)) i_egress_allocator (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (rv),
        .req_port   (rp),
        .req_head   (rh),
        .req_tail   (rt),
        .credit_ret (cr),
        .out_grant  (og),
        .xbar_sel   (xs),
        .out_valid  (ov),
        .src_pop    (sp)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic clr();
        rv = '0; rh = '0; rt = '0; cr = '0;
    endtask

    task automatic flit(input int s, input int p, input bit h, input bit t);
        rv[s] = 1'b1; rp[s] = 3'(p); rh[s] = h; rt[s] = t;
    endtask

    task automatic give(input int p, input int n);
        for (int i = 0; i < n; i++) begin
            cr[p] = 1'b1;
            cyc();
        end
        cr[p] = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 no grant", og, 0);
        chk("R1 no crossing", 32'(ov), 0);
        chk("R1 no pop", 32'(sp), 0);
    endtask

    task automatic t_basic();
        clr(); flit(1, 2, 1, 0); #1;
        chk("R2 no cross in request cycle", 32'(ov[2]), 0);
        cyc();
        chk("R2 grant owner", 32'(og[2]), 32'h02);
        chk("R2 xbar select", 32'(xs[2]), 1);
        chk("R2 head crosses", 32'(ov[2]), 1);
        chk("R2 pop", 32'(sp), 32'h02);
        cyc();
        flit(1, 2, 0, 0); #1;
        chk("R2 body crosses", 32'(ov[2]), 1);
        cyc();
        flit(1, 2, 0, 1); #1;
        chk("R6 tail crosses", 32'(ov[2]), 1);
        cyc();
        clr(); #1;
        chk("R6 idle after tail", 32'(og[2]), 0);
        give(2, 3);
    endtask

    task automatic t_head_only();
        clr(); flit(4, 0, 0, 0);
        cyc(); cyc();
        chk("R3 body no claim", 32'(og[0]), 0);
        chk("R3 body no cross", 32'(ov[0]), 0);
        chk("R3 body no pop", 32'(sp[4]), 0);
        clr(); cyc();
    endtask

    task automatic t_rr();
        clr(); flit(0, 1, 1, 1); flit(3, 1, 1, 1); flit(6, 1, 1, 1);
        cyc();
        chk("R4 first winner lowest", 32'(og[1]), 32'h01);
        chk("R4 select 0", 32'(xs[1]), 0);
        chk("R4 pop 0", 32'(sp), 32'h01);
        cyc();
        rv[0] = 1'b0; #1;
        chk("R6 idle bubble", 32'(og[1]), 0);
        cyc();
        chk("R4 second winner 3", 32'(og[1]), 32'h08);
        chk("R4 select 3", 32'(xs[1]), 3);
        cyc();
        rv[3] = 1'b0;
        cyc();
        chk("R4 third winner 6", 32'(og[1]), 32'h40);
        cyc();
        clr();
        give(1, 3);
        flit(0, 1, 1, 1); flit(7, 1, 1, 1);
        cyc();
        chk("R4 after 6 comes 7", 32'(og[1]), 32'h80);
        chk("R4 shared select 7", 32'(xs[1]), 7);
        cyc();
        rv[7] = 1'b0;
        cyc();
        chk("R4 wrap to 0", 32'(og[1]), 32'h01);
        cyc();
        clr();
        give(1, 2);
    endtask

    task automatic t_mask();
        clr(); flit(2, 3, 1, 0);
        cyc();
        chk("R5 owner 2", 32'(og[3]), 32'h04);
        flit(5, 3, 1, 1); #1;
        chk("R5 owner crosses", 32'(ov[3]), 1);
        chk("R5 only owner pops", 32'(sp), 32'h04);
        cyc();
        flit(2, 3, 0, 1); #1;
        chk("R5 owner kept", 32'(og[3]), 32'h04);
        chk("R5 intruder not popped", 32'(sp[5]), 0);
        cyc();
        rv[2] = 1'b0; #1;
        chk("R6 released", 32'(og[3]), 0);
        cyc();
        chk("R5 waiter granted", 32'(og[3]), 32'h20);
        chk("R5 waiter select", 32'(xs[3]), 5);
        chk("R5 waiter crosses", 32'(ov[3]), 1);
        cyc();
        clr();
        give(3, 3);
    endtask

    task automatic t_credit();
        clr(); flit(0, 4, 1, 0);
        cyc();
        chk("R7 grant", 32'(og[4]), 32'h01);
        chk("R7 flit1", 32'(ov[4]), 1);
        cyc();
        flit(0, 4, 0, 0); #1;
        chk("R7 flit2", 32'(ov[4]), 1);
        cyc();
        chk("R7 flit3", 32'(ov[4]), 1);
        cyc();
        chk("R1 fourth credit", 32'(ov[4]), 1);
        cyc();
        chk("R7 stalled no credit", 32'(ov[4]), 0);
        chk("R7 owner kept while stalled", 32'(og[4]), 32'h01);
        cyc();
        chk("R7 still stalled", 32'(ov[4]), 0);
        cr[4] = 1'b1;
        cyc();
        #1;
        chk("R7 resume after return", 32'(ov[4]), 1);
        cyc();
        cr[4] = 1'b0; flit(0, 4, 0, 1); #1;
        chk("R7 send plus return no stall", 32'(ov[4]), 1);
        cyc();
        clr(); flit(1, 4, 1, 1);
        cyc();
        chk("R7 zero credit no grant", 32'(og[4]), 0);
        cyc();
        chk("R7 zero credit no grant 2", 32'(og[4]), 0);
        cr[4] = 1'b1;
        cyc();
        cr[4] = 1'b0; #1;
        chk("R7 arbitrates after credit", 32'(og[4]), 0);
        cyc();
        chk("R7 grant after credit", 32'(og[4]), 32'h02);
        chk("R7 cross after credit", 32'(ov[4]), 1);
        cyc();
        clr();
        give(4, 4);
    endtask

    task automatic t_own_one();
        clr(); flit(2, 0, 1, 0);
        cyc();
        chk("R8 owns port 0", 32'(og[0]), 32'h04);
        cyc();
        flit(2, 1, 1, 1);
        cyc(); cyc();
        chk("R8 no second port", 32'(og[1]), 0);
        chk("R8 no pop", 32'(sp[2]), 0);
        flit(2, 0, 0, 1); #1;
        chk("R8 tail on owned port", 32'(ov[0]), 1);
        cyc();
        clr();
        give(0, 2);
    endtask

    task automatic t_parallel();
        clr(); flit(0, 0, 1, 1); flit(5, 2, 1, 1);
        cyc();
        chk("R9 port0 grant", 32'(og[0]), 32'h01);
        chk("R9 port2 grant", 32'(og[2]), 32'h20);
        chk("R9 both pop", 32'(sp), 32'h21);
        cyc();
        clr();
        cyc();
        give(0, 1);
        give(2, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        #1;
        t_reset();
        t_basic();
        t_head_only();
        t_rr();
        t_mask();
        t_credit();
        t_own_one();
        t_parallel();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog act=hung exp=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule